// File: doc/BRIEF.md
# Square Root Seed Estimator

This block produces a 32-bit first guess for the square root of a normalized 32-bit significand. A floating-point square-root unit uses it as the starting point for its refinement steps. The caller supplies a significand whose top bit is set, together with one bit giving the parity of the operand's exponent, and pulses a start strobe. Some cycles later the block presents the estimate and raises a one-cycle done strobe.

The estimate is built in three steps. First, a coarse seed comes from the upper significand bits, corrected by one of two 16-entry adjustment tables; the parity bit picks the table. Next, one Newton-style step averages the seed with the quotient of the operand by the seed, using a 32-by-16 restoring divider. Finally, a 64-by-32 restoring divider forms the quotient of the scaled operand by that intermediate value, and the block adds half the intermediate value to it. Both dividers retire one quotient bit per cycle. When the even-parity intermediate value already reaches the operand, the block skips the final division and returns the operand halved with its top bit kept.

Top module: `sqrt_seed_est`

## Requirements
- R1: While reset is held, and on the first cycle after release, `busy_o`, `done_o` and `est_o` are all zero.
- R2: With `exp_odd_i`=1, and `idx` = `sig_i[30:27]`, the block computes s = 0x4000 + (a>>17) − ODD[idx] and z = ((a/s)<<14) + (s<<15) (32-bit wrap). The result is (((a>>1)<<31)/z) + (z>>1), truncated to 32 bits. ODD = {0x004,0x022,0x05D,0x0B1,0x11D,0x19F,0x236,0x2E0,0x39C,0x468,0x545,0x631,0x72B,0x832,0x946,0xA67}, listed by rising idx.
- R3: With `exp_odd_i`=0, the block computes s = 0x8000 + (a>>17) − EVEN[idx] and t = (a/s) + s. It sets z = 0xFFFF8000 if t ≥ 0x20000, and z = t<<15 otherwise. When z > a, the result is ((a<<31)/z) + (z>>1), truncated to 32 bits. EVEN = {0xA2D,0x8AF,0x75A,0x629,0x51A,0x429,0x356,0x29E,0x200,0x179,0x109,0x0AF,0x068,0x034,0x012,0x002}, listed by rising idx.
- R4: With `exp_odd_i`=0 and z ≤ a, the result is {a[31], a[31:1]}, and the final division is skipped.
- R5: For every legal operand, the estimate lies within ±2 of floor(sqrt(a·2^31)) for odd parity, or of floor(sqrt(a·2^32)) for even parity.
- R6: `done_o` is high for exactly one cycle per accepted operation. `busy_o` falls on the same edge that raises `done_o`.
- R7: `est_o` changes only on the edge that raises `done_o`, and holds its value otherwise.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The running operation finishes with its own operand and its own latency.
- R9: A start taken at clock edge E raises `busy_o` after E. `done_o` is raised after edge E+99 on the full path, and after edge E+34 on the early-return path of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| sig_i | input | 32 | Normalized significand, bit 31 set |
| exp_odd_i | input | 1 | 1 when the exponent is odd |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe: estimate valid |
| est_o | output | 32 | Square root estimate, held until the next done |

## Verification
The bound checker watches the handshake on every cycle. It checks that done is a single-cycle pulse that coincides with busy falling, that starts taken while idle raise busy, and that the estimate changes only on the done edge. It also uses its own cycle counter to check that every done arrives at one of the two legal latencies. The arithmetic can only be shown by the bench's scenarios. These cover table lookups at all sixteen indices under both parities, the saturation and early-return corner near the top of the even range, the ±2 accuracy bound against an independent integer square root, and a start pulse dropped while busy.

// File: rtl/sqe_pkg.sv
package sqe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEED,
      ST_DIV1,
      ST_DIV2
   } sqe_state_t;

   // correction applied to the odd-parity seed, by index
   function automatic logic [15:0] odd_adj(input int idx);
      case (idx)
         0:  odd_adj = 16'h0004;
         1:  odd_adj = 16'h0022;
         2:  odd_adj = 16'h005D;
         3:  odd_adj = 16'h00B1;
         4:  odd_adj = 16'h011D;
         5:  odd_adj = 16'h019F;
         6:  odd_adj = 16'h0236;
         7:  odd_adj = 16'h02E0;
         8:  odd_adj = 16'h039C;
         9:  odd_adj = 16'h0468;
         10: odd_adj = 16'h0545;
         11: odd_adj = 16'h0631;
         12: odd_adj = 16'h072B;
         13: odd_adj = 16'h0832;
         14: odd_adj = 16'h0946;
         default: odd_adj = 16'h0A67;
      endcase
   endfunction

   // correction applied to the even-parity seed, by index
   function automatic logic [15:0] even_adj(input int idx);
      case (idx)
         0:  even_adj = 16'h0A2D;
         1:  even_adj = 16'h08AF;
         2:  even_adj = 16'h075A;
         3:  even_adj = 16'h0629;
         4:  even_adj = 16'h051A;
         5:  even_adj = 16'h0429;
         6:  even_adj = 16'h0356;
         7:  even_adj = 16'h029E;
         8:  even_adj = 16'h0200;
         9:  even_adj = 16'h0179;
         10: even_adj = 16'h0109;
         11: even_adj = 16'h00AF;
         12: even_adj = 16'h0068;
         13: even_adj = 16'h0034;
         14: even_adj = 16'h0012;
         default: even_adj = 16'h0002;
      endcase
   endfunction

endpackage

// File: rtl/sqe_adj_rom.sv
module sqe_adj_rom #(
   parameter int IDX_W = 4,
   parameter int ADJ_W = 12
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic             odd_i,
   output logic [ADJ_W-1:0] adj_o
);
   localparam int DEPTH = 1 << IDX_W;

   logic [ADJ_W-1:0] odd_tab  [DEPTH];
   logic [ADJ_W-1:0] even_tab [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign odd_tab[g]  = ADJ_W'(sqe_pkg::odd_adj(g));
      assign even_tab[g] = ADJ_W'(sqe_pkg::even_adj(g));
   end

   assign adj_o = odd_i ? odd_tab[idx_i] : even_tab[idx_i];
endmodule

// File: rtl/sqe_restoring_div.sv
module sqe_restoring_div #(
   parameter int NUM_W = 32,
   parameter int DEN_W = 16,
   parameter int QUO_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             fin_o,
   output logic [QUO_W-1:0] quo_o
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   if (QUO_W > NUM_W) begin : g_bad_quo
      $error("sqe_restoring_div: QUO_W must not exceed NUM_W");
   end

   logic [NUM_W-1:0] acc_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fin_q;
   logic [DEN_W:0]   trial;
   logic             fits;

   assign trial = {rem_q, acc_q[NUM_W-1]};
   assign fits  = (trial >= {1'b0, den_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         rem_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (load_i) begin
            acc_q <= num_i;
            rem_q <= '0;
            den_q <= den_i;
            cnt_q <= CNT_W'(NUM_W);
         end else if (cnt_q != '0) begin
            acc_q <= {acc_q[NUM_W-2:0], fits};
            rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
            cnt_q <= cnt_q - CNT_W'(1);
            fin_q <= (cnt_q == CNT_W'(1));
         end
      end
   end

   assign fin_o = fin_q;
   assign quo_o = acc_q[QUO_W-1:0];
endmodule

// File: rtl/sqrt_seed_est.sv
module sqrt_seed_est #(
   parameter int SIG_W = 32,
   parameter int IDX_W = 4,
   parameter int ADJ_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SIG_W-1:0] sig_i,
   input  logic             exp_odd_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [SIG_W-1:0] est_o
);
   import sqe_pkg::*;

   localparam int SEED_W  = SIG_W / 2;
   localparam int WIDE_W  = 2 * SIG_W;
   localparam int SHR     = SEED_W + 1;
   localparam int IDX_LSB = SIG_W - 1 - IDX_W;
   localparam logic [SEED_W-1:0] BASE_ODD  = SEED_W'(1) << (SEED_W - 2);
   localparam logic [SEED_W-1:0] BASE_EVEN = SEED_W'(1) << (SEED_W - 1);
   localparam logic [SIG_W-1:0]  T_LIMIT   = SIG_W'(1) << (SEED_W + 1);
   localparam logic [SIG_W-1:0]  Z_SAT     = {{(SIG_W-SEED_W+1){1'b1}}, {(SEED_W-1){1'b0}}};

   if (SIG_W != 32) begin : g_bad_sig
      $error("sqrt_seed_est: tables are tuned for a 32-bit significand");
   end
   if (IDX_W != 4) begin : g_bad_idx
      $error("sqrt_seed_est: tables hold exactly 16 entries");
   end
   if (ADJ_W < 12) begin : g_bad_adj
      $error("sqrt_seed_est: ADJ_W too narrow for table contents");
   end

   sqe_state_t        state_q;
   logic [SIG_W-1:0]  a_q;
   logic              odd_q;
   logic [SEED_W-1:0] seed_q;
   logic [SIG_W-1:0]  z_q;
   logic [SIG_W-1:0]  est_q;
   logic              done_q;

   logic [ADJ_W-1:0]  adj;
   logic [SEED_W-1:0] seed_nx;
   logic              d1_load, d1_fin;
   logic [SIG_W-1:0]  d1_quo;
   logic              d2_load, d2_fin;
   logic [SIG_W-1:0]  d2_quo;
   logic [SIG_W-1:0]  t_sum;
   logic [SIG_W-1:0]  z_nx;
   logic [SIG_W-1:0]  a_sh;
   logic              early;
   logic [WIDE_W-1:0] d2_num;

   // coarse seed from the upper significand bits
   sqe_adj_rom #(.IDX_W(IDX_W), .ADJ_W(ADJ_W)) u_rom (
      .idx_i (a_q[SIG_W-2:IDX_LSB]),
      .odd_i (odd_q),
      .adj_o (adj)
   );

   assign seed_nx = (odd_q ? BASE_ODD : BASE_EVEN)
                  + SEED_W'(a_q[SIG_W-1:SHR])
                  - SEED_W'(adj);

   // intermediate value after one averaging step
   always_comb begin
      t_sum = d1_quo + SIG_W'(seed_q);
      if (odd_q) begin
         z_nx  = (d1_quo << (SEED_W - 2)) + (SIG_W'(seed_q) << (SEED_W - 1));
         a_sh  = a_q >> 1;
         early = 1'b0;
      end else begin
         z_nx  = (t_sum >= T_LIMIT) ? Z_SAT : (t_sum << (SEED_W - 1));
         a_sh  = a_q;
         early = (z_nx <= a_q);
      end
      d2_num = {1'b0, a_sh, {(SIG_W-1){1'b0}}};
   end

   assign d1_load = (state_q == ST_SEED);
   assign d2_load = (state_q == ST_DIV1) && d1_fin && !early;

   sqe_restoring_div #(.NUM_W(SIG_W), .DEN_W(SEED_W), .QUO_W(SIG_W)) u_div_seed (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (d1_load),
      .num_i  (a_q),
      .den_i  (seed_nx),
      .fin_o  (d1_fin),
      .quo_o  (d1_quo)
   );

   sqe_restoring_div #(.NUM_W(WIDE_W), .DEN_W(SIG_W), .QUO_W(SIG_W)) u_div_final (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (d2_load),
      .num_i  (d2_num),
      .den_i  (z_nx),
      .fin_o  (d2_fin),
      .quo_o  (d2_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         a_q     <= '0;
         odd_q   <= 1'b0;
         seed_q  <= '0;
         z_q     <= '0;
         est_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  a_q     <= sig_i;
                  odd_q   <= exp_odd_i;
                  state_q <= ST_SEED;
               end
            end
            ST_SEED: begin
               seed_q  <= seed_nx;
               state_q <= ST_DIV1;
            end
            ST_DIV1: begin
               if (d1_fin) begin
                  if (early) begin
                     est_q   <= {a_q[SIG_W-1], a_q[SIG_W-1:1]};
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     z_q     <= z_nx;
                     state_q <= ST_DIV2;
                  end
               end
            end
            ST_DIV2: begin
               if (d2_fin) begin
                  est_q   <= d2_quo + (z_q >> 1);
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign est_o  = est_q;
endmodule

// File: rtl/sqrt_seed_est_chk.sv
module sqrt_seed_est_chk #(
   parameter int SIG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [SIG_W-1:0] est_o
);
   localparam int L_EARLY = SIG_W + 2;
   localparam int L_FULL  = 3 * SIG_W + 3;
   localparam int LC_W    = $clog2(L_FULL + 2);

   logic [LC_W-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lat_q <= '0;
      else if (start_i && !busy_o) lat_q <= '0;
      else if (busy_o)            lat_q <= lat_q + LC_W'(1);
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                         // R6
   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);                                   // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);                                         // R6
   AST_EST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(est_o));                                 // R7
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);                            // R9
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == LC_W'(L_FULL) || lat_q == LC_W'(L_EARLY))); // R9
endmodule

bind sqrt_seed_est sqrt_seed_est_chk #(.SIG_W(SIG_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .est_o   (est_o)
);

// File: tb/sqrt_seed_est_test.sv
`timescale 1ns/1ps
module sqrt_seed_est_test;
   localparam int L_EARLY = 34;
   localparam int L_FULL  = 99;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] sig_i = '0;
   logic        exp_odd_i = 1'b0;
   logic        busy_o, done_o;
   logic [31:0] est_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   sqrt_seed_est uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sig_i(sig_i),
      .exp_odd_i(exp_odd_i), .busy_o(busy_o), .done_o(done_o), .est_o(est_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] tab_odd(input int i);
      logic [15:0] t [16] = '{16'h004,16'h022,16'h05D,16'h0B1,16'h11D,16'h19F,16'h236,16'h2E0,
                              16'h39C,16'h468,16'h545,16'h631,16'h72B,16'h832,16'h946,16'hA67};
      return {16'b0, t[i]};
   endfunction

   function automatic logic [31:0] tab_even(input int i);
      logic [15:0] t [16] = '{16'hA2D,16'h8AF,16'h75A,16'h629,16'h51A,16'h429,16'h356,16'h29E,
                              16'h200,16'h179,16'h109,16'h0AF,16'h068,16'h034,16'h012,16'h002};
      return {16'b0, t[i]};
   endfunction

   // expected result from R2, R3, R4
   function automatic logic [31:0] ref_est(input logic [31:0] a, input bit odd);
      logic [31:0] s, z, t, aa;
      logic [63:0] q;
      int idx = int'(a[30:27]);
      if (odd) begin
         s  = 32'h4000 + (a >> 17) - tab_odd(idx);
         z  = ((a / s) << 14) + (s << 15);
         aa = a >> 1;
      end else begin
         s = 32'h8000 + (a >> 17) - tab_even(idx);
         t = (a / s) + s;
         z = (t >= 32'h20000) ? 32'hFFFF8000 : (t << 15);
         if (z <= a) return {a[31], a[31:1]};
         aa = a;
      end
      q = ({32'b0, aa} << 31) / {32'b0, z};
      return q[31:0] + (z >> 1);
   endfunction

   function automatic logic [63:0] isqrt(input logic [63:0] x);
      logic [127:0] lo = 0, hi = 128'h1_0000_0000, mid;
      while (hi - lo > 1) begin
         mid = (lo + hi) >> 1;
         if (mid * mid <= {64'b0, x}) lo = mid; else hi = mid;
      end
      return lo[63:0];
   endfunction

   task automatic run_op(input logic [31:0] a, input bit odd, output logic [31:0] est, output int lat);
      @(negedge clk);
      start_i = 1'b1; sig_i = a; exp_odd_i = odd;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 300) begin
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      est = est_o;
   endtask

   task automatic value_and_bound(input logic [31:0] a, input bit odd, input string req);
      logic [31:0] est;
      int lat;
      logic [63:0] exact;
      longint diff;
      run_op(a, odd, est, lat);
      chk(est == ref_est(a, odd), req, {32'b0, est}, {32'b0, ref_est(a, odd)});
      exact = odd ? isqrt({32'b0, a} << 31) : isqrt({a, 32'b0});
      diff  = longint'({32'b0, est}) - longint'(exact);
      chk(diff <= 2 && diff >= -2, "R5 accuracy", {32'b0, est}, exact);
   endtask

   task automatic t_reset;
      chk(busy_o == 1'b0, "R1 busy", {63'b0, busy_o}, 0);
      chk(done_o == 1'b0, "R1 done", {63'b0, done_o}, 0);
      chk(est_o == '0, "R1 est", {32'b0, est_o}, 0);
   endtask

   task automatic t_odd;
      for (int i = 0; i < 16; i++)
         value_and_bound({1'b1, 4'(i), 27'h5A5A5A5 ^ (27'(i) * 27'h0123457)}, 1'b1, "R2 odd");
      value_and_bound(32'h8000_0000, 1'b1, "R2 odd min");
      value_and_bound(32'hFFFF_FFFF, 1'b1, "R2 odd max");
   endtask

   task automatic t_even;
      for (int i = 0; i < 16; i++)
         value_and_bound({1'b1, 4'(i), 27'h2C3D4E5 ^ (27'(i) * 27'h0765431)}, 1'b0, "R3 even");
      value_and_bound(32'h8000_0000, 1'b0, "R3 even min");
   endtask

   task automatic t_early;
      logic [31:0] est;
      int lat;
      run_op(32'hFFFF_8000, 1'b0, est, lat);
      chk(est == 32'hFFFF_C000, "R4 early value", {32'b0, est}, 64'hFFFF_C000);
      chk(lat == L_EARLY, "R9 early latency", lat, L_EARLY);
      run_op(32'hFFFF_FFFF, 1'b0, est, lat);
      chk(est == 32'hFFFF_FFFF, "R4 early max", {32'b0, est}, 64'hFFFF_FFFF);
   endtask

   task automatic t_latency_pulse;
      logic [31:0] est;
      int lat;
      run_op(32'hC000_1234, 1'b1, est, lat);
      chk(lat == L_FULL, "R9 full latency", lat, L_FULL);
      chk(busy_o == 1'b0, "R6 busy low at done", {63'b0, busy_o}, 0);
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R6 done one cycle", {63'b0, done_o}, 0);
      chk(est_o == est, "R7 est held", {32'b0, est_o}, {32'b0, est});
   endtask

   task automatic t_busy_ignore;
      logic [31:0] a = 32'hA123_4567;
      int lat = 0;
      @(negedge clk);
      start_i = 1'b1; sig_i = a; exp_odd_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      repeat (5) begin @(posedge clk); @(negedge clk); lat++; end
      chk(busy_o == 1'b1, "R9 busy during op", {63'b0, busy_o}, 1);
      start_i = 1'b1; sig_i = 32'h8765_4321; exp_odd_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      lat++;
      start_i = 1'b0;
      while (!done_o && lat < 300) begin
         @(posedge clk); @(negedge clk); lat++;
      end
      chk(est_o == ref_est(a, 1'b0), "R8 ignored start value", {32'b0, est_o}, {32'b0, ref_est(a, 1'b0)});
      chk(lat == L_FULL, "R8 ignored start latency", lat, L_FULL);
      repeat (3) begin @(posedge clk); @(negedge clk); end
      chk(busy_o == 1'b0, "R8 no second op", {63'b0, busy_o}, 0);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      t_reset();
      t_odd();
      t_even();
      t_early();
      t_latency_pulse();
      t_busy_ignore();
      finish_run();
   end
endmodule